// File: doc/BRIEF.md
# Machine Interrupt Select Unit

This block decides which machine-level interrupt a hart takes next, and which cause value is reported for it. It samples four request lines into a pending register: software, timer, external, and a separate debug request. It combines the pending register with a software-writable enable register, the global enable bit and the current privilege level. At an instruction boundary it issues a one-cycle strobe and a cause word for the winning source.

The debug request sits at interrupt number 14. Its enable bit is fixed at 1 and it bypasses the global enable gate. This lets an attached debug controller stop the hart whatever software has configured. Cause encoding runs up to number 14.

The unit decodes CSR reads of both registers and CSR writes of the enable register. Trap entry, saving the program counter and vectoring are left to the core.

Top module: `mirq_unit`

## Requirements
- R1: A CSR read at address 0x344 returns the pending register, which is also driven on `pend_o`. Bit 3 follows `irq_sw`, bit 7 follows `irq_tmr`, bit 11 follows `irq_ext` and bit 14 follows `irq_dbg`, each one clock after the line changes. All other bits read 0. CSR writes to 0x344 are ignored.
- R2: A CSR write to address 0x304 updates only enable bits 3, 7 and 11. Every other bit reads 0, except bit 14, which always reads 1 and cannot be cleared.
- R3: After reset, the enable register reads 0x0000_4000, the pending register reads 0 and `take_o` is 0.
- R4: Source 3, 7 or 11 is eligible only when all of the following hold:
  - it is pending;
  - its enable bit is set;
  - `glb_ie` is 1, or `priv` is not machine level (2'b11).
- R5: A pending debug request is eligible even when `glb_ie` is 0, `priv` is machine level and software has written 0 to the enable register.
- R6: Among eligible sources, priority runs from highest to lowest as 14, 11, 3, 7.
- R7: In the cycle `take_o` is 1, `cause_o` has its top bit set and its low bits hold the winning interrupt number, so debug reports 0x8000_000E.
- R8: `take_o` rises one clock after a cycle in which `insn_boundary` was 1 and a source was eligible. It never stays high for two cycles in a row.
- R9: A CSR read at any address other than 0x304 and 0x344 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_sw | input | 1 | Machine software request |
| irq_tmr | input | 1 | Machine timer request |
| irq_ext | input | 1 | Machine external request |
| irq_dbg | input | 1 | Debug interrupt request |
| glb_ie | input | 1 | Global machine interrupt enable |
| priv | input | 2 | Current privilege level (2'b11 = machine) |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| csr_addr | input | 12 | CSR address |
| csr_wr | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for `csr_addr` |
| pend_o | output | XLEN | Pending register value |
| take_o | output | 1 | Interrupt-taken strobe |
| cause_o | output | XLEN | Cause word for the taken interrupt |

## Verification
Several things can fall in the same cycle, and the bench covers each of them with its own stimulus. One is arbitration among several sources that are pending and enabled together. The stimulus table raises mixed combinations of lines, enables, global-enable and privilege values. A pulse is expected only where R4 or R5 allows one, and the cause must name the source that R6 ranks highest.

A second collision is a held instruction boundary against a continuously pending debug request. Here the strobe must alternate between 1 and 0. A third is a CSR write to the pending address while the lines are active. A read-back must then show only the line values.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
    localparam int SRC_SW   = 3;
    localparam int SRC_TMR  = 7;
    localparam int SRC_EXT  = 11;
    localparam int SRC_DBG  = 14;
    localparam int NUM_SRC  = 4;
    localparam int CODE_W   = 4;

    localparam logic [11:0] ADDR_ENABLE  = 12'h304;
    localparam logic [11:0] ADDR_PENDING = 12'h344;
    localparam logic [1:0]  PRIV_MACHINE = 2'b11;

    // highest priority first
    localparam int PRIO_LIST [NUM_SRC] = '{SRC_DBG, SRC_EXT, SRC_SW, SRC_TMR};

    typedef struct packed {
        logic sw;
        logic tmr;
        logic ext;
        logic dbg;
    } lines_t;
endpackage

// File: rtl/mirq_enable_reg.sv
module mirq_enable_reg
    import mirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] en_val
);
    localparam logic [XLEN-1:0] WR_MASK =
        (XLEN'(1) << SRC_SW) | (XLEN'(1) << SRC_TMR) | (XLEN'(1) << SRC_EXT);
    localparam logic [XLEN-1:0] FIXED_ONE = XLEN'(1) << SRC_DBG;

    typedef struct packed {
        logic [XLEN-1:0] en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = wdata & WR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_val = st_q.en | FIXED_ONE;

    // R2: without a write the readable value holds
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_val));
endmodule

// File: rtl/mirq_pending.sv
module mirq_pending
    import mirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lines_t          lines,
    output logic [XLEN-1:0] pend_val
);
    typedef struct packed {
        lines_t src;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.src = lines;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pend_val          = '0;
        pend_val[SRC_SW]  = st_q.src.sw;
        pend_val[SRC_TMR] = st_q.src.tmr;
        pend_val[SRC_EXT] = st_q.src.ext;
        pend_val[SRC_DBG] = st_q.src.dbg;
    end

    // R1: debug bit follows the request line one clock later
    assert_dbg_tracks_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_val[SRC_DBG] == $past(lines.dbg));
endmodule

// File: rtl/mirq_prio.sv
module mirq_prio
    import mirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pend,
    input  logic [XLEN-1:0]   en,
    input  logic              glb_ie,
    input  logic [1:0]        priv,
    output logic              fire,
    output logic [CODE_W-1:0] code
);
    logic              gate;
    logic [NUM_SRC-1:0] hit;

    assign gate = glb_ie || (priv != PRIV_MACHINE);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        if (PRIO_LIST[i] == SRC_DBG) begin : g_dbg
            assign hit[i] = pend[PRIO_LIST[i]] & en[PRIO_LIST[i]];
        end else begin : g_std
            assign hit[i] = pend[PRIO_LIST[i]] & en[PRIO_LIST[i]] & gate;
        end
    end

    always_comb begin
        fire = |hit;
        code = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                code = CODE_W'(PRIO_LIST[i]);
            end
        end
    end
endmodule

// File: rtl/mirq_unit.sv
module mirq_unit
    import mirq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_sw,
    input  logic            irq_tmr,
    input  logic            irq_ext,
    input  logic            irq_dbg,
    input  logic            glb_ie,
    input  logic [1:0]      priv,
    input  logic            insn_boundary,
    input  logic [11:0]     csr_addr,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] pend_o,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
    } state_t;

    state_t st_d, st_q;

    lines_t              lines;
    logic [XLEN-1:0]     en_val;
    logic [XLEN-1:0]     pend_val;
    logic                fire;
    logic [CODE_W-1:0]   code;
    logic                en_wr;

    assign lines = '{sw: irq_sw, tmr: irq_tmr, ext: irq_ext, dbg: irq_dbg};
    assign en_wr = csr_wr && (csr_addr == ADDR_ENABLE);

    mirq_enable_reg #(.XLEN(XLEN)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (en_wr),
        .wdata  (csr_wdata),
        .en_val (en_val)
    );

    mirq_pending #(.XLEN(XLEN)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (lines),
        .pend_val (pend_val)
    );

    mirq_prio #(.XLEN(XLEN)) u_prio (
        .pend   (pend_val),
        .en     (en_val),
        .glb_ie (glb_ie),
        .priv   (priv),
        .fire   (fire),
        .code   (code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = insn_boundary && fire && !st_q.take;
        if (st_d.take) begin
            st_d.cause = {1'b1, {PAD_W{1'b0}}, code};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (csr_addr)
            ADDR_ENABLE:  csr_rdata = en_val;
            ADDR_PENDING: csr_rdata = pend_val;
            default:      csr_rdata = '0;
        endcase
    end

    assign pend_o  = pend_val;
    assign take_o  = st_q.take;
    assign cause_o = st_q.cause;

    // R8: a strobe follows a boundary cycle
    assert_take_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(insn_boundary));
    // R8: strobe lasts one cycle
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    // R7: interrupt flag in cause
    assert_cause_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]);
    // R5: pending debug at a boundary is always taken, as code 14
    assert_dbg_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_val[SRC_DBG] && insn_boundary && !take_o)
            |=> (take_o && cause_o[CODE_W-1:0] == CODE_W'(SRC_DBG)));
    // R4: non-debug takes need the global gate open
    assert_gate_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o[CODE_W-1:0] != CODE_W'(SRC_DBG))
            |-> $past(glb_ie || priv != PRIV_MACHINE));
endmodule

// File: tb/mirq_unit_bench.sv
`timescale 1ns/1ps
module mirq_unit_bench;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_sw = 0, irq_tmr = 0, irq_ext = 0, irq_dbg = 0;
    logic            glb_ie = 0;
    logic [1:0]      priv = 2'b11;
    logic            insn_boundary = 0;
    logic [11:0]     csr_addr = '0;
    logic            csr_wr = 0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata, pend_o, cause_o;
    logic            take_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    mirq_unit #(.XLEN(XLEN)) u_mirq_unit (
        .clk(clk), .rst_n(rst_n),
        .irq_sw(irq_sw), .irq_tmr(irq_tmr), .irq_ext(irq_ext), .irq_dbg(irq_dbg),
        .glb_ie(glb_ie), .priv(priv), .insn_boundary(insn_boundary),
        .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .pend_o(pend_o), .take_o(take_o), .cause_o(cause_o)
    );

    typedef struct packed {
        logic       ext, tmr, sw, dbg;
        logic       en_ext, en_tmr, en_sw;
        logic       glb;
        logic [1:0] pv;
        logic       take;
        logic [3:0] code;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1, 2'b11, 1'b0, 4'd0 },  // R4 nothing pending
        '{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 1'b1, 2'b11, 1'b1, 4'd3 },  // R4 sw
        '{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 1'b0, 2'b11, 1'b0, 4'd0 },  // R4 gate closed
        '{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1, 1'b0, 2'b00, 1'b1, 4'd3 },  // R4 user level
        '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1, 2'b11, 1'b0, 4'd0 },  // R4 not enabled
        '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0, 1'b1, 2'b11, 1'b1, 4'd7 },  // R4 timer
        '{1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, 2'b11, 1'b1, 4'd3 },  // R6 sw over tmr
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'b11, 1'b1, 4'd11},  // R6 ext first
        '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b0, 2'b11, 1'b1, 4'd14},  // R5 debug unmasked
        '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0, 1'b1, 2'b11, 1'b1, 4'd14},  // R6 debug first
        '{1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 1'b0, 2'b01, 1'b1, 4'd11},  // R4 supervisor
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1, 1'b1, 2'b11, 1'b0, 4'd0 }   // R4 ext disabled
    };

    task automatic chk(input string rid, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rid, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        csr_addr = 12'h304; #1;
        chk("R3 enable after reset", csr_rdata, 32'h0000_4000);
        csr_addr = 12'h344; #1;
        chk("R3 pending after reset", csr_rdata, 32'h0);
        chk("R3 take after reset", {31'b0, take_o}, 32'h0);

        // R2 writable mask and fixed debug bit
        @(negedge clk);
        csr_addr = 12'h304; csr_wdata = 32'hFFFF_FFFF; csr_wr = 1;
        @(negedge clk);
        csr_wr = 0; #1;
        chk("R2 write all ones", csr_rdata, 32'h0000_4888);
        csr_wdata = 32'h0; csr_wr = 1;
        @(negedge clk);
        csr_wr = 0; #1;
        chk("R2 bit14 survives clear", csr_rdata, 32'h0000_4000);

        // R1 pending reflects lines, writes ignored
        irq_sw = 1; irq_tmr = 1; irq_ext = 1; irq_dbg = 1;
        csr_addr = 12'h344;
        @(negedge clk); #1;
        chk("R1 pending all lines", csr_rdata, 32'h0000_4888);
        chk("R1 pend_o all lines", pend_o, 32'h0000_4888);
        csr_wdata = 32'h0; csr_wr = 1;
        @(negedge clk);
        csr_wr = 0; #1;
        chk("R1 write to pending ignored", csr_rdata, 32'h0000_4888);
        irq_sw = 0; irq_tmr = 0; irq_dbg = 0;
        @(negedge clk); #1;
        chk("R1 pending ext only", csr_rdata, 32'h0000_0800);
        irq_ext = 0;

        // R9 unmapped address
        csr_addr = 12'h300; #1;
        chk("R9 unmapped read", csr_rdata, 32'h0);
        @(negedge clk);

        // table: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_ext = VEC[i].ext; irq_tmr = VEC[i].tmr; irq_sw = VEC[i].sw; irq_dbg = VEC[i].dbg;
            csr_addr  = 12'h304;
            csr_wdata = (32'(VEC[i].en_ext) << 11) | (32'(VEC[i].en_tmr) << 7) | (32'(VEC[i].en_sw) << 3);
            csr_wr = 1; glb_ie = VEC[i].glb; priv = VEC[i].pv; insn_boundary = 0;
            @(negedge clk);
            csr_wr = 0; insn_boundary = 1;
            @(negedge clk);
            insn_boundary = 0;
            chk($sformatf("R4/R5/R6 take vec %0d", i), {31'b0, take_o}, {31'b0, VEC[i].take});
            if (VEC[i].take)
                chk($sformatf("R7 cause vec %0d", i), cause_o, {1'b1, 27'b0, VEC[i].code});
            @(negedge clk);
        end

        // R8 held boundary with debug pending: alternating pulse
        irq_ext = 0; irq_tmr = 0; irq_sw = 0; irq_dbg = 1; glb_ie = 0; priv = 2'b11;
        @(negedge clk);
        @(negedge clk);
        insn_boundary = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk($sformatf("R8 held boundary cycle %0d", k), {31'b0, take_o}, {31'b0, (k % 2 == 0)});
        end
        insn_boundary = 0;
        // R8 no boundary, no take
        @(negedge clk);
        @(negedge clk);
        chk("R8 no boundary", {31'b0, take_o}, 32'h0);
        irq_dbg = 0;
        @(negedge clk);
        finish_run();
    end
endmodule